// File: doc/BRIEF.md
# Tagged Branch Target Buffer

This block sits in the fetch stage and supplies the address to fetch next, before the current instruction has been decoded. A direct-mapped table, indexed by the low word-address bits of the fetch PC, holds a valid flag, the complete PC of a control-transfer instruction and the address it last jumped to. When the fetch PC matches a valid stored PC, the stored address is offered as the next PC. Otherwise the block offers the sequential address, fetch PC plus four.

The table is written only from the branch resolution stage, through a valid/ready update channel. Each update carries the PC of a resolved control-transfer instruction, its target and whether it was taken. A taken outcome allocates the entry, or overwrites whatever sat at that index. A not-taken outcome removes the entry only if it belongs to that same PC. The update channel never applies back-pressure: `upd_ready` is held high, and a beat is accepted on every clock edge where `upd_valid` is high. Non-control instructions are never presented on this channel.

Because the whole PC is compared, an ordinary instruction whose address shares an index with a stored branch falls through to PC+4. It never inherits a stale target. The lookup path is combinational from the table state, so a lookup never sees an update made in the same cycle.

Top module: `btb_predictor`

## Requirements
- R1: After reset, every entry is invalid, so every lookup misses until a taken update has been accepted.
- R2: On a miss, `pred_hit` is 0 and `pred_next_pc` equals `fetch_pc + 4` (modulo 2^PC_W).
- R3: A hit requires the stored PC to equal `fetch_pc` in all PC_W bits. A PC that maps to the same index but differs in any other bit misses.
- R4: On a hit, `pred_hit` is 1 and `pred_next_pc` equals the stored target.
- R5: An accepted update with `upd_taken`=1 writes valid, `upd_pc` and `upd_target` into the entry at the index of `upd_pc`. This replaces any previous occupant.
- R6: An accepted update with `upd_taken`=0 whose `upd_pc` equals the stored PC of a valid entry clears that entry's valid bit.
- R7: An accepted update with `upd_taken`=0 whose `upd_pc` does not match the stored PC leaves the entry, including its target, unchanged.
- R8: The index is `fetch_pc[IDX_W+1:2]` (likewise for `upd_pc`), with IDX_W = log2(ENTRIES). Entries at different indices never affect each other.
- R9: A lookup in the same cycle as an update to its index sees the contents from before the update. The new contents are visible from the next cycle.
- R10: When `upd_valid` is 0, the table does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_hit | output | 1 | Lookup matched a valid entry |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| upd_valid | input | 1 | Resolution update beat present |
| upd_ready | output | 1 | Always 1; updates are never stalled |
| upd_pc | input | PC_W | PC of the resolved control-transfer instruction |
| upd_target | input | PC_W | Resolved target address |
| upd_taken | input | 1 | 1 = taken (allocate), 0 = not taken (clear on match) |

## Verification
On every cycle, the assertions check several relations. The cold table never hits. A miss always yields the sequential address. The cycle after a taken update, a lookup of that PC returns its target. The cycle after a not-taken update, that PC misses. With no update and an unchanged fetch PC, the prediction holds still. The bench scenarios cover what needs a chosen history. These are an aliasing PC at an occupied index, replacement of one branch by another, a not-taken update from a foreign PC that must spare the entry, independent entries at neighbouring indices, and the same-cycle read of old contents.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // What a resolution beat does to the addressed entry.
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_WRITE = 2'd1,
    ACT_CLEAR = 2'd2
  } btb_act_e;

  localparam int unsigned WORD_OFFSET = 2;
endpackage

// File: rtl/btb_update_decode.sv
module btb_update_decode
  import btb_pkg::*;
(
  input  logic     upd_valid,
  input  logic     upd_taken,
  input  logic     owner_match,
  output btb_act_e act
);
  always_comb begin
    act = ACT_NONE;
    if (upd_valid) begin
      if (upd_taken)        act = ACT_WRITE;
      else if (owner_match) act = ACT_CLEAR;
    end
  end
endmodule

// File: rtl/btb_table.sv
module btb_table
  import btb_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ENTRIES = 128,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [PC_W-1:0]  rd_pc,
  output logic [PC_W-1:0]  rd_target,
  input  logic [IDX_W-1:0] up_idx,
  output logic             up_valid_q,
  output logic [PC_W-1:0]  up_pc_q,
  input  btb_act_e         act,
  input  logic [PC_W-1:0]  wr_pc,
  input  logic [PC_W-1:0]  wr_target
);
  logic [ENTRIES-1:0] valid_q;
  logic [PC_W-1:0]    tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];

  // Fetch-side read port and update-side owner check: both from current state.
  assign rd_valid   = valid_q[rd_idx];
  assign rd_pc      = tag_q[rd_idx];
  assign rd_target  = tgt_q[rd_idx];
  assign up_valid_q = valid_q[up_idx];
  assign up_pc_q    = tag_q[up_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      case (act)
        ACT_WRITE: valid_q[up_idx] <= 1'b1;
        ACT_CLEAR: valid_q[up_idx] <= 1'b0;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (act == ACT_WRITE) begin
      tag_q[up_idx] <= wr_pc;
      tgt_q[up_idx] <= wr_target;
    end
  end
endmodule

// File: rtl/btb_next_pc.sv
module btb_next_pc #(
  parameter int unsigned PC_W = 32
) (
  input  logic            ent_valid,
  input  logic [PC_W-1:0] ent_pc,
  input  logic [PC_W-1:0] ent_target,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            hit,
  output logic [PC_W-1:0] next_pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  assign hit     = ent_valid && (ent_pc == fetch_pc);
  assign next_pc = hit ? ent_target : fetch_pc + STEP;
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ENTRIES = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_hit,
  output logic [PC_W-1:0] pred_next_pc,
  input  logic            upd_valid,
  output logic            upd_ready,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_taken
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned IDX_LO = WORD_OFFSET;
  localparam int unsigned IDX_HI = WORD_OFFSET + IDX_W - 1;

  logic [IDX_W-1:0] f_idx, u_idx;
  logic             ent_valid, own_valid;
  logic [PC_W-1:0]  ent_pc, ent_tgt, own_pc;
  logic             owner_match;
  btb_act_e         act;

  assign f_idx       = fetch_pc[IDX_HI:IDX_LO];
  assign u_idx       = upd_pc[IDX_HI:IDX_LO];
  assign upd_ready   = 1'b1;
  assign owner_match = own_valid && (own_pc == upd_pc);

  btb_update_decode u_dec (
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken),
    .owner_match(owner_match),
    .act        (act)
  );

  btb_table #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_tab (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (f_idx),
    .rd_valid  (ent_valid),
    .rd_pc     (ent_pc),
    .rd_target (ent_tgt),
    .up_idx    (u_idx),
    .up_valid_q(own_valid),
    .up_pc_q   (own_pc),
    .act       (act),
    .wr_pc     (upd_pc),
    .wr_target (upd_target)
  );

  btb_next_pc #(.PC_W(PC_W)) u_sel (
    .ent_valid (ent_valid),
    .ent_pc    (ent_pc),
    .ent_target(ent_tgt),
    .fetch_pc  (fetch_pc),
    .hit       (pred_hit),
    .next_pc   (pred_next_pc)
  );
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic            pred_hit,
  input logic [PC_W-1:0] pred_next_pc,
  input logic            upd_valid,
  input logic [PC_W-1:0] upd_pc,
  input logic [PC_W-1:0] upd_target,
  input logic            upd_taken
);
  logic live_q, seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (upd_valid && upd_taken) seen_q <= 1'b1;
    end
  end

  // R1: nothing can hit before the first taken update
  p_cold_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !pred_hit);

  // R2: a miss always falls through to the sequential address
  p_fallthrough_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_hit |-> pred_next_pc == fetch_pc + PC_W'(4));

  // R5/R4/R9: the cycle after a taken update, that PC hits with its target
  p_alloc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(upd_valid && upd_taken) && fetch_pc == $past(upd_pc))
      |-> (pred_hit && pred_next_pc == $past(upd_target)));

  // R6: the cycle after a not-taken update, that PC misses
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(upd_valid && !upd_taken) && fetch_pc == $past(upd_pc))
      |-> !pred_hit);

  // R10: idle update channel and steady fetch PC give a steady prediction
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !$past(upd_valid) && fetch_pc == $past(fetch_pc))
      |-> (pred_hit == $past(pred_hit) && pred_next_pc == $past(pred_next_pc)));
endmodule

bind btb_predictor btb_checker #(.PC_W(PC_W)) u_btb_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_pc    (fetch_pc),
  .pred_hit    (pred_hit),
  .pred_next_pc(pred_next_pc),
  .upd_valid   (upd_valid),
  .upd_pc      (upd_pc),
  .upd_target  (upd_target),
  .upd_taken   (upd_taken)
);

// File: tb/btb_predictor_test.sv
module btb_predictor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_hit;
  logic [31:0] pred_next_pc;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic [31:0] upd_pc = '0;
  logic [31:0] upd_target = '0;
  logic        upd_taken = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  btb_predictor #(.PC_W(32), .ENTRIES(128)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_next_pc(pred_next_pc),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_pc(upd_pc),
    .upd_target(upd_target), .upd_taken(upd_taken)
  );

  // Lookup is combinational: set PC after a falling edge, sample 1 ns later.
  task automatic expect_pc(input string req, input logic [31:0] pc,
                           input logic exp_hit, input logic [31:0] exp_next);
    fetch_pc = pc;
    #1;
    n_tests++;
    if (pred_hit !== exp_hit || pred_next_pc !== exp_next) begin
      n_fail++;
      $display("FAIL %s pc=%h: hit=%0b next=%h, expected hit=%0b next=%h",
               req, pc, pred_hit, pred_next_pc, exp_hit, exp_next);
    end
  endtask

  // One update beat, accepted on the next rising edge.
  task automatic send(input logic [31:0] pc, input logic [31:0] tgt, input logic tk);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_target = tgt; upd_taken = tk;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic t_reset;
    n_tests++;
    if (upd_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 upd_ready=%0b expected 1", upd_ready);
    end
    expect_pc("R1", 32'h0000_0100, 1'b0, 32'h0000_0104);
    expect_pc("R2", 32'hFFFF_FFFC, 1'b0, 32'h0000_0000);
  endtask

  task automatic t_alloc;
    send(32'h0000_0100, 32'h0000_2000, 1'b1);
    expect_pc("R4", 32'h0000_0100, 1'b1, 32'h0000_2000);
    expect_pc("R2", 32'h0000_0104, 1'b0, 32'h0000_0108);
  endtask

  task automatic t_alias;
    // 0x300 shares index 0x40 with 0x100
    expect_pc("R3", 32'h0000_0300, 1'b0, 32'h0000_0304);
    expect_pc("R3", 32'h8000_0100, 1'b0, 32'h8000_0104);
  endtask

  task automatic t_neighbours;
    send(32'h0000_0104, 32'h0000_3000, 1'b1);
    expect_pc("R8", 32'h0000_0104, 1'b1, 32'h0000_3000);
    expect_pc("R8", 32'h0000_0100, 1'b1, 32'h0000_2000);
  endtask

  task automatic t_replace;
    send(32'h0000_0300, 32'h0000_4000, 1'b1);
    expect_pc("R5", 32'h0000_0300, 1'b1, 32'h0000_4000);
    expect_pc("R5", 32'h0000_0100, 1'b0, 32'h0000_0104);
  endtask

  task automatic t_foreign_clear;
    send(32'h0000_0100, 32'h0, 1'b0);
    expect_pc("R7", 32'h0000_0300, 1'b1, 32'h0000_4000);
  endtask

  task automatic t_clear;
    send(32'h0000_0300, 32'h0, 1'b0);
    expect_pc("R6", 32'h0000_0300, 1'b0, 32'h0000_0304);
    expect_pc("R8", 32'h0000_0104, 1'b1, 32'h0000_3000);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = 32'h0000_0104; upd_target = 32'h0000_5000; upd_taken = 1'b1;
    expect_pc("R9", 32'h0000_0104, 1'b1, 32'h0000_3000);
    @(negedge clk);
    upd_valid = 1'b0;
    expect_pc("R9", 32'h0000_0104, 1'b1, 32'h0000_5000);
  endtask

  task automatic t_idle;
    @(negedge clk);
    upd_valid = 1'b0; upd_pc = 32'h0000_0104; upd_target = 32'h0000_6000; upd_taken = 1'b1;
    @(negedge clk);
    @(negedge clk);
    expect_pc("R10", 32'h0000_0104, 1'b1, 32'h0000_5000);
    upd_taken = 1'b0;
    @(negedge clk);
    @(negedge clk);
    expect_pc("R10", 32'h0000_0104, 1'b1, 32'h0000_5000);
  endtask

  task automatic t_reset_again;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_pc("R1", 32'h0000_0104, 1'b0, 32'h0000_0108);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alloc();
    t_alias();
    t_neighbours();
    t_replace();
    t_foreign_clear();
    t_clear();
    t_same_cycle();
    t_idle();
    t_reset_again();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule